// File: doc/BRIEF.md
# Early Receive Interrupt Controller

This block follows the bytes of each incoming receive frame and raises an interrupt while the frame is still arriving. It does not wait for the end of the frame. A per-frame counter starts on the start-of-frame byte. When the counter first equals a programmable threshold, a status flag is set. The address filter must have accepted the frame, the function must be switched on, and the receiver must be in neither monitor mode nor loopback mode.

Software controls the block through one 8-bit control/status register. A small register port reads and writes it. The register holds an enable bit, an interrupt-mask bit and a sticky status bit. Writing 1 to the status bit clears it. The mask bit affects only the output pin. The output `irq_n` is an active-low level and stays asserted until software clears the status bit.

Top module: `early_rx_irq`

## Requirements
- R1: After reset, the enable, mask and status bits are 0, the register reads 0x00 and `irq_n` is 1.
- R2: The register is at address 0x0B. Its fields are bit 0 enable, bit 1 mask and bit 7 status, and the other bits read 0. Any other address reads 0x00, and writes to other addresses have no effect.
- R3: The byte counter loads 1 on a byte that carries `sof` and adds 1 on each later byte of that frame. It stops at its maximum value and does not wrap.
- R4: The status bit becomes 1 on the clock edge that takes in the byte on which the count equals `thresh`. It does this only if enable is 1 and `da_match` is high on that byte. It sets at most once per frame.
- R5: A frame whose `da_match` is low on the threshold byte does not set status.
- R6: A threshold of 0 never sets status. A frame that ends before reaching the threshold does not set status.
- R7: A register write of 1 to bit 7 clears status, and a write of 0 to bit 7 leaves it unchanged. Bits 0 and 1 take the written values.
- R8: If a status set and a write-1 clear fall on the same edge, status ends up 1.
- R9: `irq_n` is low exactly when both status and mask are 1. It follows the register with no added delay. Status still sets while mask is 0.
- R10: While `mon_mode` or `lpbk_mode` is high, status cannot set, even with enable at 1.
- R11: A byte strobe outside a frame is not counted. This covers strobes after an `eof` byte and strobes before any `sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One received byte this cycle |
| sof | input | 1 | Byte is the first byte of a frame |
| eof | input | 1 | Byte is the last byte of a frame |
| da_match | input | 1 | Destination address of the current frame accepted |
| thresh | input | CNT_W | Early threshold in bytes |
| mon_mode | input | 1 | Receiver in monitor mode |
| lpbk_mode | input | 1 | Receiver in loopback mode |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low early interrupt |

## Verification
Register writes and byte events take effect on the first rising edge after they are driven. Reads and `irq_n` have no registers between state and port, so each result can be seen on the falling edge that follows that rising edge. The bench drives every input on a falling edge and samples on a later falling edge, after the last byte or write has passed a full rising edge. This keeps each check one register stage behind its stimulus. The same-edge set/clear case drives the clear write together with the threshold byte. It then reads one cycle later.

// File: rtl/early_rx_irq.sv
module early_rx_irq #(
  parameter int CNT_W = 12,
  parameter logic [3:0] CSR_ADDR = 4'hB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             da_match,
  input  logic [CNT_W-1:0] thresh,
  input  logic             mon_mode,
  input  logic             lpbk_mode,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en_q, mask_q, status_q;
  logic             in_frame_q, fired_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             acc, active, hit, csr_sel, clr;

  assign csr_sel = (reg_addr == CSR_ADDR);
  assign acc     = byte_vld && (sof || in_frame_q);
  assign cnt_nxt = sof ? CNT_W'(1) : (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign active  = en_q && !mon_mode && !lpbk_mode;
  assign hit     = acc && active && da_match && (thresh != '0) &&
                   (cnt_nxt == thresh) && (sof || !fired_q);
  assign clr     = reg_wr && csr_sel && reg_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      fired_q    <= 1'b0;
    end else if (acc) begin
      cnt_q      <= cnt_nxt;
      in_frame_q <= !eof;
      fired_q    <= hit || (fired_q && !sof);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (reg_wr && csr_sel) begin
        en_q   <= reg_wdata[0];
        mask_q <= reg_wdata[1];
      end
      if (hit)      status_q <= 1'b1;
      else if (clr) status_q <= 1'b0;
    end
  end

  assign reg_rdata = csr_sel ? {status_q, 5'b0, mask_q, en_q} : 8'h00;
  assign irq_n     = !(status_q && mask_q);
endmodule

module early_rx_irq_chk #(
  parameter int CNT_W = 12,
  parameter logic [3:0] CSR_ADDR = 4'hB
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             sof,
  input logic             da_match,
  input logic [CNT_W-1:0] thresh,
  input logic             mon_mode,
  input logic             lpbk_mode,
  input logic [3:0]       reg_addr,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic             en_q,
  input logic             mask_q,
  input logic             status_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic wsel;
  assign wsel = reg_wr && (reg_addr == CSR_ADDR);

  AST_SET_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(en_q && byte_vld && da_match)); // R4
  AST_MODE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(!mon_mode && !lpbk_mode)); // R10
  AST_THR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(thresh != '0)); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel && reg_wdata[7] && !byte_vld) |=> !status_q); // R7
  AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !(wsel && reg_wdata[7])) |=> status_q); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !sof && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |-> irq_n); // R9
endmodule

bind early_rx_irq early_rx_irq_chk #(.CNT_W(CNT_W), .CSR_ADDR(CSR_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .da_match(da_match),
  .thresh(thresh), .mon_mode(mon_mode), .lpbk_mode(lpbk_mode), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .en_q(en_q), .mask_q(mask_q),
  .status_q(status_q), .cnt_q(cnt_q), .irq_n(irq_n));

// File: tb/early_rx_irq_tb.sv
module early_rx_irq_tb_top;
  localparam int CNT_W = 12;
  localparam int NV = 10;
  // {thr[22:15], nbytes[14:7], match, en, mask, mon, lpbk, exp_status, exp_irq_n}
  localparam logic [22:0] VEC [NV] = '{
    {8'd5, 8'd8, 7'b1110010},  // R4 R9 fires mid-frame
    {8'd5, 8'd8, 7'b1100011},  // R9 mask 0: status set, irq high
    {8'd5, 8'd4, 7'b1110001},  // R6 frame too short
    {8'd5, 8'd5, 7'b1110010},  // R4 threshold on last byte
    {8'd5, 8'd8, 7'b0110001},  // R5 no address match
    {8'd0, 8'd8, 7'b1110001},  // R6 threshold zero
    {8'd5, 8'd8, 7'b1010001},  // R4 disabled
    {8'd5, 8'd8, 7'b1111001},  // R10 monitor
    {8'd5, 8'd8, 7'b1110101},  // R10 loopback
    {8'd1, 8'd1, 7'b1110010}   // R3 first byte counts 1
  };

  logic clk = 0, rst_n = 0;
  logic byte_vld = 0, sof = 0, eof = 0, da_match = 0, mon_mode = 0, lpbk_mode = 0;
  logic [CNT_W-1:0] thresh = '0;
  logic [3:0] reg_addr = 4'hB;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_n;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  early_rx_irq #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_addr = 4'hB;
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1; sof = (i == 0); eof = (i == n - 1);
    end
    @(negedge clk); byte_vld = 0; sof = 0; eof = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp_rd, input logic exp_irq);
    reg_addr = 4'hB; #1;
    chk(req, reg_rdata, exp_rd);
    chk(req, {7'b0, irq_n}, {7'b0, exp_irq});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_chk("R1 reset", 8'h00, 1'b1);
    rst_n = 1;
    @(negedge clk);
    rd_chk("R1 after release", 8'h00, 1'b1);

    foreach (VEC[k]) begin
      logic [22:0] v;
      v = VEC[k];
      thresh = {4'b0, v[22:15]};
      da_match = v[6]; mon_mode = v[3]; lpbk_mode = v[2];
      wr(4'hB, {1'b1, 5'b0, v[4], v[5]});
      frame(int'(v[14:7]));
      rd_chk($sformatf("R4/R9 vector %0d", k), {v[1], 5'b0, v[4], v[5]}, v[0]);
    end
    mon_mode = 0; lpbk_mode = 0; da_match = 1;

    // R2 other address reads 0, write there ignored
    wr(4'hB, 8'h83);
    wr(4'h3, 8'h00);
    reg_addr = 4'h3; #1; chk("R2 other addr read", reg_rdata, 8'h00);
    rd_chk("R2 write elsewhere ignored", 8'h03, 1'b1);

    // R7 write 0 to status keeps it; write 1 clears
    thresh = 12'd2;
    frame(3);
    rd_chk("R7 set", 8'h83, 1'b0);
    wr(4'hB, 8'h03);
    rd_chk("R7 write 0 keeps", 8'h83, 1'b0);
    wr(4'hB, 8'h81);
    rd_chk("R7 write 1 clears", 8'h01, 1'b1);

    // R4 once per frame: clear mid-frame, no re-set
    thresh = 12'd2; wr(4'hB, 8'h83);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_vld = 1; sof = (i == 0); eof = 0;
    end
    @(negedge clk); byte_vld = 0; sof = 0;
    reg_addr = 4'hB; reg_wdata = 8'h83; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_vld = 1; eof = (i == 3);
    end
    @(negedge clk); byte_vld = 0; eof = 0;
    rd_chk("R4 once per frame", 8'h03, 1'b1);

    // R8 set and clear on the same edge
    thresh = 12'd3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_vld = 1; sof = (i == 0); eof = (i == 2);
      if (i == 2) begin reg_addr = 4'hB; reg_wdata = 8'h83; reg_wr = 1; end
    end
    @(negedge clk); byte_vld = 0; sof = 0; eof = 0; reg_wr = 0;
    rd_chk("R8 set wins", 8'h83, 1'b0);

    // R11 stray bytes after eof are not counted
    wr(4'hB, 8'h83);
    thresh = 12'd3;
    frame(2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_vld = 1;
    end
    @(negedge clk); byte_vld = 0;
    rd_chk("R11 stray bytes", 8'h03, 1'b1);

    // R3 counter reaches its maximum
    thresh = {CNT_W{1'b1}};
    frame(4095 + 5);
    rd_chk("R3 max threshold", 8'h83, 1'b0);

    finish_run();
  end
endmodule